// File: doc/BRIEF.md
# Nonvolatile Shadow Transfer Controller

This block sequences bulk copies between a byte-wide working array and a shadow array of equal depth. The shadow array can be refreshed from the working array (a store), and the working array can be refilled from the shadow array (a recall). A recall is started either by a software request or automatically after the supply recovers from a deep dip. The requests arrive as single-cycle pulses from an upstream sequence detector. The supply condition arrives as two digital flags: one set when the supply is under the low reset threshold, and one set when it is under the higher switch threshold.

Each operation has two phases. Each phase walks the address counter through every location once, one address per clock, and asserts one array strobe. A store runs erase, then program. A recall runs clear, then load. A duration counter keeps `busy` high for a configured number of cycles. That number is never shorter than the two walks. The block has no data path: the strobes and the address drive the arrays directly. For this reason every pin is plain control or status, with no handshake.

Top module: `nvx_shadow_ctrl`

## Requirements
- R1: During and right after reset, `busy` and all four strobes are low, and a power-up recall request is pending.
- R2: A store strobes `sh_erase` for addresses 0 to DEPTH-1 in rising order, one per cycle, then `sh_prog` over the same range. Afterwards the shadow array equals the working array.
- R3: A recall strobes `wk_clear` over all addresses and then `wk_load` over all addresses. Afterwards the working array equals the shadow array. No shadow strobe fires during a recall.
- R4: `busy` rises on the clock edge that samples an accepted request. It stays high for exactly STORE_CYC cycles for a store and SREC_CYC cycles for a software recall. Each count is raised to 2*DEPTH when set smaller.
- R5: While `below_reset` is high, a power-up recall request is latched. It starts on the first edge at which the block is idle and both flags are low. `busy` then lasts PREC_CYC cycles.
- R6: A dip that raises only `below_switch` and never `below_reset` causes no recall when the flag clears.
- R7: `store_req` is ignored while `below_switch` or `below_reset` is high. `recall_req` is ignored while `below_reset` is high. A software recall is allowed while only `below_switch` is high.
- R8: A request pulse that arrives while `busy` is high is dropped. The running operation keeps its length, and no operation follows it.
- R9: If `below_reset` is high on an edge while `busy` is high, the block returns to idle on that edge and latches a power-up recall request.
- R10: At most one strobe is high in any cycle. Within a phase, `arr_addr` increases by exactly one each cycle.
- R11: A pending power-up recall takes precedence over a software request sampled on the same edge, and that request is dropped. A store request takes precedence over a recall request sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| store_req | input | 1 | Software store request pulse |
| recall_req | input | 1 | Software recall request pulse |
| below_reset | input | 1 | Supply is under the reset threshold |
| below_switch | input | 1 | Supply is under the switch threshold |
| busy | output | 1 | Transfer in progress; the arrays are not available |
| arr_addr | output | ADDR_W | Address for the active strobe |
| sh_erase | output | 1 | Erase shadow location at `arr_addr` |
| sh_prog | output | 1 | Program shadow location from working location |
| wk_clear | output | 1 | Clear working location |
| wk_load | output | 1 | Load working location from shadow location |

## Verification
A wrong phase or address state shows in the cycle after it occurs, through the arrays the strobes drive. A skipped or repeated address leaves a location in one array that does not match the other. A reversed phase order leaves erased or cleared bytes behind. A wrong duration or timer state shows on the edge where `busy` should fall, so busy is counted to the exact cycle. A lost or stuck power-up request shows as a recall that is missing, or an extra one, on the first edge at which both supply flags are low.

// File: rtl/nvx_pkg.sv
package nvx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ERASE = 3'd1,
    PH_PROG  = 3'd2,
    PH_CLEAR = 3'd3,
    PH_LOAD  = 3'd4,
    PH_HOLD  = 3'd5
  } phase_t;

  function automatic logic is_walk(phase_t p);
    return (p == PH_ERASE) || (p == PH_PROG) || (p == PH_CLEAR) || (p == PH_LOAD);
  endfunction

  function automatic phase_t after_walk(phase_t p);
    case (p)
      PH_ERASE: return PH_PROG;
      PH_CLEAR: return PH_LOAD;
      default:  return PH_HOLD;
    endcase
  endfunction
endpackage

// File: rtl/nvx_pend_latch.sv
module nvx_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic take_i,
  output logic pend_o
);
  // Power-on is itself a deep supply dip, so reset leaves a request pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_o <= 1'b1;
    else if (set_i)  pend_o <= 1'b1;
    else if (take_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/nvx_timer.sv
module nvx_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] limit_i,
  input  logic          run_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = run_i && (cnt_q == lim_q - 1'b1);
endmodule

// File: rtl/nvx_shadow_ctrl.sv
module nvx_shadow_ctrl #(
  parameter int ADDR_W    = 11,
  parameter int STORE_CYC = 1000000,
  parameter int SREC_CYC  = 2000,
  parameter int PREC_CYC  = 55000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_req,
  input  logic              recall_req,
  input  logic              below_reset,
  input  logic              below_switch,
  output logic              busy,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              sh_erase,
  output logic              sh_prog,
  output logic              wk_clear,
  output logic              wk_load
);
  import nvx_pkg::*;

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int MIN_CYC = 2 * DEPTH;
  localparam int ST_EFF  = (STORE_CYC < MIN_CYC) ? MIN_CYC : STORE_CYC;
  localparam int SR_EFF  = (SREC_CYC  < MIN_CYC) ? MIN_CYC : SREC_CYC;
  localparam int PR_EFF  = (PREC_CYC  < MIN_CYC) ? MIN_CYC : PREC_CYC;
  localparam int MAX_A   = (ST_EFF > SR_EFF) ? ST_EFF : SR_EFF;
  localparam int MAX_EFF = (MAX_A > PR_EFF) ? MAX_A : PR_EFF;
  localparam int CW      = $clog2(MAX_EFF + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  phase_t            ph_q;
  logic [ADDR_W-1:0] addr_q;
  logic              pend_q;
  logic              idle, pu_go, st_go, rc_go, any_go, t_last;
  logic [CW-1:0]     limit_sel;

  assign idle   = (ph_q == PH_IDLE);
  assign pu_go  = idle && pend_q && !below_switch && !below_reset;
  assign st_go  = idle && !pu_go && store_req && !below_switch && !below_reset;
  assign rc_go  = idle && !pu_go && !st_go && recall_req && !below_reset;
  assign any_go = pu_go || st_go || rc_go;

  always_comb begin
    if (pu_go)      limit_sel = CW'(PR_EFF);
    else if (st_go) limit_sel = CW'(ST_EFF);
    else            limit_sel = CW'(SR_EFF);
  end

  nvx_pend_latch u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (below_reset),
    .take_i (pu_go),
    .pend_o (pend_q)
  );

  nvx_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (any_go),
    .limit_i (limit_sel),
    .run_i   (!idle),
    .last_o  (t_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      addr_q <= '0;
    end else if (idle) begin
      addr_q <= '0;
      if (st_go)               ph_q <= PH_ERASE;
      else if (pu_go || rc_go) ph_q <= PH_CLEAR;
    end else if (below_reset || t_last) begin
      ph_q   <= PH_IDLE;
      addr_q <= '0;
    end else if (is_walk(ph_q)) begin
      if (addr_q == LAST_ADDR) begin
        addr_q <= '0;
        ph_q   <= after_walk(ph_q);
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign busy     = !idle;
  assign arr_addr = addr_q;
  assign sh_erase = (ph_q == PH_ERASE);
  assign sh_prog  = (ph_q == PH_PROG);
  assign wk_clear = (ph_q == PH_CLEAR);
  assign wk_load  = (ph_q == PH_LOAD);
endmodule

// File: rtl/nvx_shadow_chk.sv
module nvx_shadow_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              below_reset,
  input logic              below_switch,
  input logic              pend,
  input logic              busy,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              sh_erase,
  input logic              sh_prog,
  input logic              wk_clear,
  input logic              wk_load
);
  logic [3:0] strb;
  assign strb = {sh_erase, sh_prog, wk_clear, wk_load};

  // R7
  store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && sh_erase) |-> (!$past(below_switch) && !$past(below_reset)));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && below_reset) |=> !busy);

  // R2
  erase_then_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sh_erase) && busy) |-> sh_prog);

  // R3
  clear_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wk_clear) && busy) |-> wk_load);

  // R10
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb != 4'b0) && (strb == $past(strb))) |-> (arr_addr == ADDR_W'($past(arr_addr) + 1'b1)));

  // R5
  powerup_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(busy) && $past(pend) && !$past(below_switch) && !$past(below_reset))
      |-> (busy && wk_clear));
endmodule

bind nvx_shadow_ctrl nvx_shadow_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .below_reset  (below_reset),
  .below_switch (below_switch),
  .pend         (pend_q),
  .busy         (busy),
  .arr_addr     (arr_addr),
  .sh_erase     (sh_erase),
  .sh_prog      (sh_prog),
  .wk_clear     (wk_clear),
  .wk_load      (wk_load)
);

// File: tb/nvx_shadow_ctrl_test.sv
module nvx_shadow_ctrl_test;
  localparam int AW   = 3;
  localparam int DEP  = 1 << AW;
  localparam int T_ST = 40;
  localparam int T_SR = 20;
  localparam int T_PR = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic store_req = 1'b0, recall_req = 1'b0;
  logic below_reset = 1'b1, below_switch = 1'b1;
  logic busy, sh_erase, sh_prog, wk_clear, wk_load;
  logic [AW-1:0] arr_addr;

  int checks = 0;
  int errors = 0;
  bit timed_out = 1'b0;

  always #5 clk = ~clk;

  nvx_shadow_ctrl #(.ADDR_W(AW), .STORE_CYC(T_ST), .SREC_CYC(T_SR), .PREC_CYC(T_PR)) uut (
    .clk(clk), .rst_n(rst_n), .store_req(store_req), .recall_req(recall_req),
    .below_reset(below_reset), .below_switch(below_switch), .busy(busy),
    .arr_addr(arr_addr), .sh_erase(sh_erase), .sh_prog(sh_prog),
    .wk_clear(wk_clear), .wk_load(wk_load)
  );

  // array models driven by the strobes
  logic [7:0] wk [DEP];
  logic [7:0] sh [DEP];
  logic       fill_go = 1'b0, fill_sh = 1'b0;
  logic [7:0] fill_seed = 8'h00;

  always @(posedge clk) begin
    if (fill_go) begin
      for (int i = 0; i < DEP; i++) begin
        if (fill_sh) sh[i] = fill_seed + 8'(i * 37);
        else         wk[i] = fill_seed + 8'(i * 37);
      end
    end
    if (sh_erase) sh[arr_addr] = 8'hFF;
    if (sh_prog)  sh[arr_addr] = wk[arr_addr];
    if (wk_clear) wk[arr_addr] = 8'h00;
    if (wk_load)  wk[arr_addr] = sh[arr_addr];
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic fill(input bit to_sh, input logic [7:0] seed);
    fill_sh = to_sh; fill_seed = seed; fill_go = 1'b1;
    @(negedge clk);
    fill_go = 1'b0;
  endtask

  function automatic int mismatches();
    int n = 0;
    for (int i = 0; i < DEP; i++) if (wk[i] !== sh[i]) n++;
    return n;
  endfunction

  task automatic measure(output int n);
    n = 0;
    while (busy && n < 500) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse(input bit is_store);
    if (is_store) store_req = 1'b1; else recall_req = 1'b1;
    @(negedge clk);
    store_req = 1'b0; recall_req = 1'b0;
  endtask

  task automatic quiet(input int cyc, input string rq);
    int hi = 0;
    for (int i = 0; i < cyc; i++) begin
      if (busy) hi++;
      @(negedge clk);
    end
    chk(hi == 0, rq, hi, 0);
  endtask

  // {store(1)/recall(0), below_switch, expected busy length}
  localparam logic [9:0] VEC [5] = '{
    {1'b1, 1'b0, 8'd40},
    {1'b0, 1'b0, 8'd20},
    {1'b1, 1'b1, 8'd0},
    {1'b0, 1'b1, 8'd20},
    {1'b1, 1'b0, 8'd40}
  };

  task automatic run_all();
    int n;
    logic [7:0] snap [DEP];
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !sh_erase && !sh_prog && !wk_clear && !wk_load, "R1", busy, 0);
    rst_n = 1'b1;
    fill(1'b1, 8'h05);
    below_reset = 1'b0;
    quiet(4, "R5");                   // still below switch: must wait
    below_switch = 1'b0;              // crossing: R1 pending recall fires
    @(negedge clk);
    measure(n);
    chk(n == T_PR, "R5", n, T_PR);
    chk(mismatches() == 0, "R3", mismatches(), 0);

    // table walk
    for (int v = 0; v < 5; v++) begin
      fill(1'b0, 8'(8'h21 + v * 13));
      for (int i = 0; i < DEP; i++) snap[i] = sh[i];
      below_switch = VEC[v][8];
      pulse(VEC[v][9]);
      measure(n);
      chk(n == int'(VEC[v][7:0]), VEC[v][9] ? "R4 store" : "R4 recall", n, int'(VEC[v][7:0]));
      if (VEC[v][7:0] == 0) begin
        chk(sh == snap, "R7", mismatches(), -1);
      end else if (VEC[v][9]) begin
        chk(mismatches() == 0, "R2", mismatches(), 0);
      end else begin
        chk(mismatches() == 0 && sh == snap, "R3", mismatches(), 0);
      end
      below_switch = 1'b0;
      @(negedge clk);
    end

    // R6: shallow dip
    below_switch = 1'b1;
    repeat (5) @(negedge clk);
    below_switch = 1'b0;
    quiet(6, "R6");

    // R8: request while busy
    fill(1'b0, 8'h77);
    pulse(1'b1);
    repeat (4) @(negedge clk);
    pulse(1'b0);
    measure(n);
    chk(n == T_ST - 5, "R8", n, T_ST - 5);
    chk(mismatches() == 0, "R8", mismatches(), 0);
    quiet(5, "R8");

    // R9: abort during store
    fill(1'b0, 8'h90);
    pulse(1'b1);
    repeat (9) @(negedge clk);
    below_reset = 1'b1; below_switch = 1'b1;
    @(negedge clk);
    chk(!busy, "R9", busy, 0);
    repeat (2) @(negedge clk);
    below_reset = 1'b0;
    quiet(3, "R9");
    fill(1'b1, 8'h3C);
    below_switch = 1'b0;
    @(negedge clk);
    measure(n);
    chk(n == T_PR, "R9", n, T_PR);
    chk(mismatches() == 0, "R9", mismatches(), 0);

    // R11: pending power-up recall beats a store on the same edge
    below_reset = 1'b1; below_switch = 1'b1;
    repeat (2) @(negedge clk);
    below_reset = 1'b0;
    fill(1'b0, 8'hA5);
    for (int i = 0; i < DEP; i++) snap[i] = sh[i];
    below_switch = 1'b0;
    pulse(1'b1);
    measure(n);
    chk(n == T_PR, "R11", n, T_PR);
    chk(mismatches() == 0 && sh == snap, "R11", mismatches(), 0);

    // R11: store beats recall when both pulse together
    fill(1'b0, 8'h4B);
    store_req = 1'b1; recall_req = 1'b1;
    @(negedge clk);
    store_req = 1'b0; recall_req = 1'b0;
    measure(n);
    chk(n == T_ST, "R11", n, T_ST);
    chk(mismatches() == 0, "R2", mismatches(), 0);

    // R7: software recall ignored below reset threshold
    below_reset = 1'b1; below_switch = 1'b1;
    pulse(1'b0);
    chk(!busy, "R7", busy, 0);
    below_reset = 1'b0; below_switch = 1'b0;
    @(negedge clk);
    measure(n);                       // the latched recall runs now
    chk(n == T_PR, "R5", n, T_PR);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule